// File: doc/BRIEF.md
# Core Module System Control Register File

This block is a bank of system control registers for a processor core module. It sits on a simple 32-bit register bus. The bus carries a word offset, a write strobe and write data. Reads are combinational from the offset, so the read data is valid in the same cycle as the address. The bank holds the following:

- Two oscillator setting words, which accept writes only while a lock word holds a magic key.
- A control word. Its stored bits drive a memory remap select and an indicator LED. A write-only bit in it requests a system reset.
- Volatile and non-volatile flag words. Each has its own set address and its own clear address.
- Writable memory-controller setup and init words.
- A free-running reference counter.
- Fixed identification and status words.

At power-up, both reset inputs are asserted. A reset that the block requests itself reaches the block only through `rst_n`. Because of this, the non-volatile flags survive that reset. Only `por_n` clears them. The reference counter advances once per `ref_tick` pulse. The clock enable is expected to pulse at 24 MHz, so the count reads in 24 MHz units.

Top module: `core_ctrl_regs`

## Requirements
- R1: A write to word 5 (lock) stores the low 16 bits of the data. A read of word 5 returns 0x0001A05F when the stored value is 0xA05F, and otherwise returns the stored value zero-extended. The lock resets to 0.
- R2: Writes to word 2 (oscillator) and word 7 (auxiliary oscillator) update the register only while the lock holds 0xA05F. Otherwise the write leaves the register unchanged.
- R3: A write to word 3 (control) stores only data bits 0 and 2. A read of word 3 returns zero in every other bit, including bit 3. `led_on` follows stored bit 0.
- R4: A write to word 3 with data bit 3 set raises `reset_req` on the following cycle, for exactly one cycle.
- R5: `remap_sel` follows stored control bit 2. 0 selects boot flash at address zero, and 1 selects RAM there.
- R6: A write to word 12 ORs the data into the flag register. A write to word 13 clears the bits that are set in the data. A read of word 12 returns the flags. `rst_n` clears the flags.
- R7: Words 14 and 15 set and clear the non-volatile flags in the same way, and a read of word 14 returns them. They keep their value through `rst_n` and are cleared only by `por_n`.
- R8: A read of word 0 returns 0x411A3001, and a read of word 4 returns 0x00100000.
- R9: After reset, the registers read as follows:
  - oscillator: 0x01000048
  - auxiliary oscillator: 0x0007FEFF
  - init: 0x00000112
  - setup: 0x00011122 ORed with a size code from `MEM_MB`. The code is 0x10 for 256 or more, 0x0C for 128 or more, 0x08 for 64 or more, 0x04 for 32 or more, and 0 below that. The default of 128 gives 0x0001112E.
- R10: Word 10 reads a 32-bit counter. `rst_n` clears it, it adds one on each cycle with `ref_tick` high, it holds otherwise, and it wraps modulo 2^32.
- R11: Reads of any word not listed here return zero, and this includes the clear addresses 13 and 15. Writes to unlisted words change no register.
- R12: Writes to word 8 (setup) and word 9 (init) store the full 32-bit data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of all state except the non-volatile flags |
| por_n | input | 1 | Synchronous active-low power-on reset of the non-volatile flags |
| ref_tick | input | 1 | Reference counter clock enable, one pulse per reference period |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 6 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| remap_sel | output | 1 | 1 = RAM at address zero, 0 = boot flash |
| reset_req | output | 1 | Single-cycle system reset request |
| led_on | output | 1 | Indicator LED state |

## Verification
The register map is walked with a table of write-then-read pairs. Each oscillator write is issued three times: while locked, after the key is written, and after the key is replaced by a near-miss value. This separates a lock that gates writes from one that is ignored or that never re-locks.

The flags are driven with overlapping set and clear patterns. Because the patterns overlap, OR and AND-NOT semantics can be told apart from plain stores.

The control word is written with all-ones bytes to show the bit masking, and directed sequences cover the remaining behaviour:
- the timing of the reset pulse
- survival of the non-volatile flags across `rst_n`
- counting against gaps in `ref_tick`

// File: rtl/ccr_pkg.sv
// Package: word offsets, constant words and reset values shared by the
// core module control register file. Assumes 32-bit data.
package ccr_pkg;

    localparam int W_ID       = 0;
    localparam int W_OSC      = 2;
    localparam int W_CTRL     = 3;
    localparam int W_STAT     = 4;
    localparam int W_LOCK     = 5;
    localparam int W_AUXOSC   = 7;
    localparam int W_SETUP    = 8;
    localparam int W_INIT     = 9;
    localparam int W_REFCNT   = 10;
    localparam int W_FLAG_SET = 12;   // set; +1 is clear; +2/+3 non-volatile pair

    localparam logic [31:0] ID_WORD    = 32'h411A_3001;
    localparam logic [31:0] STAT_WORD  = 32'h0010_0000;
    localparam logic [15:0] LOCK_KEY   = 16'hA05F;
    localparam logic [31:0] OSC_RST    = 32'h0100_0048;
    localparam logic [31:0] AUXOSC_RST = 32'h0007_FEFF;
    localparam logic [31:0] INIT_RST   = 32'h0000_0112;

    // Control word bit positions.
    localparam int CTRL_LED   = 0;
    localparam int CTRL_REMAP = 2;
    localparam int CTRL_RESET = 3;

    // Setup register reset value, including the memory size code.
    function automatic logic [31:0] setup_reset(input int mem_mb);
        logic [31:0] code;
        if (mem_mb >= 256)      code = 32'h10;
        else if (mem_mb >= 128) code = 32'h0C;
        else if (mem_mb >= 64)  code = 32'h08;
        else if (mem_mb >= 32)  code = 32'h04;
        else                    code = 32'h00;
        return 32'h0001_1122 | code;
    endfunction

endpackage

// File: rtl/ccr_lock_osc.sv
// Lock word and the two oscillator words it guards.
// Assumes the write strobes are already decoded and mutually exclusive.
module ccr_lock_osc
    import ccr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_lock,
    input  logic              we_osc,
    input  logic              we_aux,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] lock_rd,
    output logic [DATA_W-1:0] osc_q,
    output logic [DATA_W-1:0] aux_q
);

    localparam int KEY_W = $bits(LOCK_KEY);

    logic [KEY_W-1:0] lock_q;
    logic             unlocked;

    assign unlocked = (lock_q == LOCK_KEY);

    // Lock value: keep the low half of each write.
    always_ff @(posedge clk) begin
        if (!rst_n)       lock_q <= '0;
        else if (we_lock) lock_q <= wdata[KEY_W-1:0];
    end

    // Oscillator words: write only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osc_q <= OSC_RST;
            aux_q <= AUXOSC_RST;
        end else if (unlocked) begin
            if (we_osc) osc_q <= wdata;
            if (we_aux) aux_q <= wdata;
        end
    end

    // Readback: unlocked state reports an extra status bit above the key.
    always_comb begin
        lock_rd           = DATA_W'(lock_q);
        lock_rd[KEY_W]    = unlocked;
    end

    AST_OSC_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (we_osc && lock_q != LOCK_KEY) |=> (osc_q == $past(osc_q))); // R2
    AST_AUX_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (we_aux && lock_q != LOCK_KEY) |=> (aux_q == $past(aux_q))); // R2

endmodule

// File: rtl/ccr_ctrl.sv
// Control word: stores the LED and remap bits, turns a write of the reset
// bit into a one-cycle request. Assumes we is a decoded word strobe.
module ccr_ctrl
    import ccr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_rd,
    output logic              remap_sel,
    output logic              led_on,
    output logic              reset_req
);

    localparam logic [DATA_W-1:0] KEEP_MASK =
        (DATA_W'(1) << CTRL_LED) | (DATA_W'(1) << CTRL_REMAP);

    logic [DATA_W-1:0] ctrl_q;
    logic              req_now;

    assign req_now = we && wdata[CTRL_RESET];

    // Stored control bits: masked update.
    always_ff @(posedge clk) begin
        if (!rst_n)  ctrl_q <= '0;
        else if (we) ctrl_q <= wdata & KEEP_MASK;
    end

    // Reset request: one cycle, never two in a row.
    always_ff @(posedge clk) begin
        if (!rst_n) reset_req <= 1'b0;
        else        reset_req <= req_now && !reset_req;
    end

    assign ctrl_rd   = ctrl_q;
    assign remap_sel = ctrl_q[CTRL_REMAP];
    assign led_on    = ctrl_q[CTRL_LED];

    AST_RESET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req); // R4
    AST_RESET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |-> $past(we)); // R4

endmodule

// File: rtl/ccr_setclr_reg.sv
// Flag word with separate set and clear strobes; set wins if both occur.
// Assumes a caller-chosen reset so one instance can survive system reset.
module ccr_setclr_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] val
);

    // Flag update: OR on set, AND-NOT on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      val <= '0;
        else if (set_we) val <= val | wdata;
        else if (clr_we) val <= val & ~wdata;
    end

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_we || clr_we) |=> $stable(val)); // R6
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((val & $past(wdata)) == $past(wdata))); // R6
    AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we) |=> ((val & $past(wdata)) == '0)); // R6

endmodule

// File: rtl/ccr_refcnt.sv
// Free-running reference counter advanced by a clock enable; wraps.
// Assumes tick is synchronous to clk.
module ccr_refcnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);

    // Count: add one per tick, natural wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (tick) count <= count + 1'b1;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (count == $past(count) + 1'b1)); // R10
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count)); // R10

endmodule

// File: rtl/core_ctrl_regs.sv
// Core module control register file top: write decode, setup/init words,
// flag banks, read multiplexer. Assumes word offsets and combinational reads.
module core_ctrl_regs
    import ccr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 32,
    parameter int MEM_MB = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              ref_tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              remap_sel,
    output logic              reset_req,
    output logic              led_on
);

    localparam int NWORDS = 2 ** ADDR_W;
    localparam int NBANKS = 2;
    localparam logic [DATA_W-1:0] SETUP_RST = DATA_W'(setup_reset(MEM_MB));

    logic [NWORDS-1:0] we_dec;
    logic [DATA_W-1:0] lock_rd, osc_q, aux_q, ctrl_rd;
    logic [DATA_W-1:0] setup_q, init_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] flag_q [NBANKS];

    assign we_dec = bus_we ? (NWORDS'(1) << bus_addr) : '0;

    ccr_lock_osc #(.DATA_W(DATA_W)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_lock (we_dec[W_LOCK]),
        .we_osc  (we_dec[W_OSC]),
        .we_aux  (we_dec[W_AUXOSC]),
        .wdata   (bus_wdata),
        .lock_rd (lock_rd),
        .osc_q   (osc_q),
        .aux_q   (aux_q)
    );

    ccr_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (we_dec[W_CTRL]),
        .wdata     (bus_wdata),
        .ctrl_rd   (ctrl_rd),
        .remap_sel (remap_sel),
        .led_on    (led_on),
        .reset_req (reset_req)
    );

    // Flag banks: bank 0 volatile, bank 1 survives system reset.
    for (genvar g = 0; g < NBANKS; g++) begin : g_flag
        logic bank_rst_n;
        assign bank_rst_n = (g == 0) ? rst_n : por_n;
        ccr_setclr_reg #(.DATA_W(DATA_W)) u_bank (
            .clk    (clk),
            .rst_n  (bank_rst_n),
            .set_we (we_dec[W_FLAG_SET + 2 * g]),
            .clr_we (we_dec[W_FLAG_SET + 2 * g + 1]),
            .wdata  (bus_wdata),
            .val    (flag_q[g])
        );
    end

    ccr_refcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ref_tick),
        .count (cnt_q)
    );

    // Setup and init words: plain full-width stores.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_q <= SETUP_RST;
            init_q  <= INIT_RST;
        end else begin
            if (we_dec[W_SETUP]) setup_q <= bus_wdata;
            if (we_dec[W_INIT])  init_q  <= bus_wdata;
        end
    end

    // Read multiplexer: unlisted words read zero.
    always_comb begin
        case (int'(bus_addr))
            W_ID:           bus_rdata = ID_WORD;
            W_OSC:          bus_rdata = osc_q;
            W_CTRL:         bus_rdata = ctrl_rd;
            W_STAT:         bus_rdata = STAT_WORD;
            W_LOCK:         bus_rdata = lock_rd;
            W_AUXOSC:       bus_rdata = aux_q;
            W_SETUP:        bus_rdata = setup_q;
            W_INIT:         bus_rdata = init_q;
            W_REFCNT:       bus_rdata = DATA_W'(cnt_q);
            W_FLAG_SET:     bus_rdata = flag_q[0];
            W_FLAG_SET + 2: bus_rdata = flag_q[1];
            default:        bus_rdata = '0;
        endcase
    end

    AST_NV_KEEP: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_n && !we_dec[W_FLAG_SET + 2] && !we_dec[W_FLAG_SET + 3])
        |=> $stable(flag_q[1])); // R7
    AST_SETUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we_dec[W_SETUP] |=> $stable(setup_q)); // R12

endmodule

// File: tb/tb_core_ctrl_regs.sv
`timescale 1ns/1ps
module tb_core_ctrl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        remap_sel, reset_req, led_on;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    core_ctrl_regs dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .ref_tick(ref_tick),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .remap_sel(remap_sel),
        .reset_req(reset_req), .led_on(led_on)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        we;
        logic [5:0]  wa;
        logic [31:0] wd;
        logic [5:0]  ra;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VEC [NV] = '{
        '{4'd8,  1'b0, 6'd0,  32'h0,         6'd0,  32'h411A3001}, // R8
        '{4'd8,  1'b0, 6'd0,  32'h0,         6'd4,  32'h00100000}, // R8
        '{4'd9,  1'b0, 6'd0,  32'h0,         6'd2,  32'h01000048}, // R9
        '{4'd9,  1'b0, 6'd0,  32'h0,         6'd7,  32'h0007FEFF}, // R9
        '{4'd9,  1'b0, 6'd0,  32'h0,         6'd9,  32'h00000112}, // R9
        '{4'd9,  1'b0, 6'd0,  32'h0,         6'd8,  32'h0001112E}, // R9
        '{4'd1,  1'b0, 6'd0,  32'h0,         6'd5,  32'h00000000}, // R1
        '{4'd2,  1'b1, 6'd2,  32'h12345678,  6'd2,  32'h01000048}, // R2 locked
        '{4'd2,  1'b1, 6'd7,  32'hAAAA5555,  6'd7,  32'h0007FEFF}, // R2 locked
        '{4'd1,  1'b1, 6'd5,  32'hFFFFA05F,  6'd5,  32'h0001A05F}, // R1
        '{4'd2,  1'b1, 6'd2,  32'h12345678,  6'd2,  32'h12345678}, // R2
        '{4'd2,  1'b1, 6'd7,  32'hAAAA5555,  6'd7,  32'hAAAA5555}, // R2
        '{4'd1,  1'b1, 6'd5,  32'h0000A05E,  6'd5,  32'h0000A05E}, // R1
        '{4'd2,  1'b1, 6'd2,  32'h00000000,  6'd2,  32'h12345678}, // R2 relocked
        '{4'd3,  1'b1, 6'd3,  32'h000000F7,  6'd3,  32'h00000005}, // R3
        '{4'd3,  1'b1, 6'd3,  32'h00000004,  6'd3,  32'h00000004}, // R3
        '{4'd6,  1'b1, 6'd12, 32'h000000F0,  6'd12, 32'h000000F0}, // R6
        '{4'd6,  1'b1, 6'd12, 32'h0F000001,  6'd12, 32'h0F0000F1}, // R6
        '{4'd6,  1'b1, 6'd13, 32'h00000030,  6'd12, 32'h0F0000C1}, // R6
        '{4'd11, 1'b0, 6'd0,  32'h0,         6'd13, 32'h00000000}, // R11
        '{4'd7,  1'b1, 6'd14, 32'h80000003,  6'd14, 32'h80000003}, // R7
        '{4'd7,  1'b1, 6'd15, 32'h00000001,  6'd14, 32'h80000002}, // R7
        '{4'd12, 1'b1, 6'd8,  32'hDEADBEEF,  6'd8,  32'hDEADBEEF}, // R12
        '{4'd12, 1'b1, 6'd9,  32'h00C0FFEE,  6'd9,  32'h00C0FFEE}, // R12
        '{4'd11, 1'b1, 6'd40, 32'hFFFFFFFF,  6'd40, 32'h00000000}, // R11
        '{4'd11, 1'b1, 6'd6,  32'h00000001,  6'd6,  32'h00000000}, // R11
        '{4'd11, 1'b0, 6'd0,  32'h0,         6'd1,  32'h00000000}  // R11
    };

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [5:0] a,
                            input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;

        // Reset state of the outputs: R3 R4 R5
        #1;
        check("R5 remap after reset", {31'b0, remap_sel}, 32'd0);
        check("R3 led after reset", {31'b0, led_on}, 32'd0);
        check("R4 reset_req idle", {31'b0, reset_req}, 32'd0);
        rd_check("R10 counter after reset", 6'd10, 32'd0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].we) wr(VEC[i].wa, VEC[i].wd);
            rd_check($sformatf("R%0d vector %0d", VEC[i].req, i),
                     VEC[i].ra, VEC[i].exp);
        end

        // Remap and LED outputs: control holds 4 here. R5 R3
        #1;
        check("R5 remap set", {31'b0, remap_sel}, 32'd1);
        check("R3 led clear", {31'b0, led_on}, 32'd0);
        wr(6'd3, 32'h00000001);
        #1;
        check("R5 remap cleared", {31'b0, remap_sel}, 32'd0);
        check("R3 led set", {31'b0, led_on}, 32'd1);

        // Reset request pulse. R4
        wr(6'd3, 32'h00000008);
        #1;
        check("R4 pulse high", {31'b0, reset_req}, 32'd1);
        rd_check("R3 bit3 reads zero", 6'd3, 32'd0);
        @(negedge clk); #1;
        check("R4 pulse one cycle", {31'b0, reset_req}, 32'd0);

        // Reference counter. R10
        @(negedge clk); ref_tick = 1'b1;
        repeat (5) @(negedge clk);
        ref_tick = 1'b0;
        rd_check("R10 five ticks", 6'd10, 32'd5);
        repeat (3) @(negedge clk);
        rd_check("R10 hold without tick", 6'd10, 32'd5);
        ref_tick = 1'b1; @(negedge clk); ref_tick = 1'b0;
        rd_check("R10 one more tick", 6'd10, 32'd6);

        // System reset only: non-volatile flags survive. R7 R6 R1
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        rd_check("R7 nv flags survive rst_n", 6'd14, 32'h80000002);
        rd_check("R6 flags cleared by rst_n", 6'd12, 32'd0);
        rd_check("R1 lock cleared by rst_n", 6'd5, 32'd0);
        rd_check("R9 setup after rst_n", 6'd8, 32'h0001112E);

        // Power-on reset clears them. R7
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        rd_check("R7 nv flags cleared by por_n", 6'd14, 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule